// File: doc/BRIEF.md
# Dependency-Gated Power Rail Sequencer

This block decides, for each of a set of power rails, when the rail's enable pin is driven active and when it is released. A rail turns on only when its command-on input is high and every condition selected by its turn-on masks holds: chosen general-purpose inputs must be high and chosen other rails must report power-good. The command and the conditions may arrive in either order. Once on, a rail ignores its turn-on conditions. A normal turn-off waits for the turn-off conditions: chosen inputs low and chosen rails no longer power-good. An immediate-off request skips those conditions and the turn-off delay.

Both delays count pulses of a shared millisecond tick. A fault on a rail shuts it down. The fault also shuts down every rail named in that rail's fault-slave mask. Each rail shut down this way is latched off until it sees a low-to-high edge on its command input, or on one of the inputs selected in its turn-on input mask.

Configuration is written one rail at a time through a plain write strobe. The strobe always completes in one cycle, so there is no back-pressure. Writing a rail releases its enable. The rail is then evaluated again from the off state.

Top module: `rail_sequencer`

## Requirements
- R1: A rail leaves the off state only when every input selected in its turn-on input mask is high and every present rail selected in its turn-on rail mask has its power-good input high.
- R2: A rail also needs its command-on input high to turn on. When the conditions of R1 are met first, the rail waits for the command. When the command comes first, the rail waits for the conditions.
- R3: With a turn-on delay of N (8 bits), the enable asserts on the clock edge of the N-th tick after the conditions were first seen met. With N = 0 it asserts on the clock edge after the conditions are met. During the delay, the rail stays off while no tick arrives.
- R4: An on rail whose command-on input stays high remains on, whatever its turn-on inputs and rail power-good values do.
- R5: After the command-on input drops, an on rail stays on until every input in its turn-off input mask is low and every present rail in its turn-off rail mask has power-good low. The turn-off delay of M ticks then runs, and the enable releases on the edge of the M-th tick. With M = 0 it releases on the next edge.
- R6: An immediate-off request turns the rail off on the next clock edge. It does so regardless of the turn-off conditions and the delay.
- R7: A high fault input on rail i turns off, on the next edge, rail i and every rail j whose bit j is set in the fault-slave mask of rail i. All of these rails become latched in the fault state.
- R8: A rail in the fault state stays off until, with no fault acting on it, it sees a rising edge on its command-on input or on one of its turn-on mask inputs. It then returns to the off state. From there it can turn on under R1 and R2 one cycle later.
- R9: A configuration write to rail k (cfg_sel = k) releases that rail's enable on the next edge. If its conditions still hold, the rail re-enables on the following edge with a zero delay. A rail in the fault state stays in the fault state. A write with cfg_sel at or above NUM_RAILS changes nothing.
- R10: The enable pin equals the rail's on state XOR the rail's polarity bit.
- R11: Bits of the rail masks at index NUM_RAILS or above are treated as satisfied for both turn-on and turn-off.
- R12: After reset, every mask, delay and polarity bit is zero, every rail is off and every enable pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond, used by the delays |
| gpi | input | NUM_GPI | General-purpose sequencing inputs |
| rail_pg | input | NUM_RAILS | Power-good status of each rail |
| cmd_on | input | NUM_RAILS | Per-rail command to be on |
| imm_off | input | NUM_RAILS | Per-rail immediate turn-off request |
| rail_fault | input | NUM_RAILS | Per-rail fault indication |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Index of the rail being written |
| cfg_on_gpi | input | NUM_GPI | Turn-on input mask |
| cfg_off_gpi | input | NUM_GPI | Turn-off input mask |
| cfg_on_rail | input | MASK_W | Turn-on rail power-good mask |
| cfg_off_rail | input | MASK_W | Turn-off rail power-good mask |
| cfg_slave | input | NUM_RAILS | Fault-slave mask |
| cfg_ton | input | DLY_W | Turn-on delay in ticks |
| cfg_toff | input | DLY_W | Turn-off delay in ticks |
| cfg_pol | input | 1 | Enable pin polarity (1 = active low) |
| en_pin | output | NUM_RAILS | Enable pin per rail |

## Verification
The hardest state to reach from the ports is a slave rail that a master fault latched off. That rail must still need its own rearm edge after the master has already recovered through a different edge. The vector table first turns on both the master and the slave. It then faults the master. Next it holds the command steady, so that no rearm happens, and then toggles it. A second fault follows, and this time the master is rearmed only through a rising turn-on input that is not in the slave's mask, which leaves the slave off. The zero-delay cases, the absent mask bit and the turn-on conditions falling away while a rail is on are placed in the same table. The timed delays and the release and re-enable after a configuration write are covered by directed steps that pulse the tick by hand.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_ON_DLY = 3'd1,
    ST_ON     = 3'd2,
    ST_OFF_DLY = 3'd3,
    ST_FAULT  = 3'd4
  } rail_st_e;
endpackage

// File: rtl/seq_dep_eval.sv
module seq_dep_eval #(
  parameter int NUM_RAILS = 4,
  parameter int MASK_W    = 16,
  parameter int NUM_GPI   = 8
) (
  input  logic [NUM_GPI-1:0]   gpi,
  input  logic [NUM_GPI-1:0]   gpi_q,
  input  logic [NUM_RAILS-1:0] rail_pg,
  input  logic [NUM_GPI-1:0]   on_gpi_m,
  input  logic [NUM_GPI-1:0]   off_gpi_m,
  input  logic [MASK_W-1:0]    on_rail_m,
  input  logic [MASK_W-1:0]    off_rail_m,
  output logic                 on_ok,
  output logic                 off_ok,
  output logic                 gpi_rise
);
  // Mask bits for rails that do not exist are dropped (R11).
  localparam logic [MASK_W-1:0] PRESENT = MASK_W'((64'd1 << NUM_RAILS) - 64'd1);

  logic [MASK_W-1:0] pg_ext;
  logic [MASK_W-1:0] on_sel;
  logic [MASK_W-1:0] off_sel;

  always_comb begin
    pg_ext  = MASK_W'(rail_pg);
    on_sel  = on_rail_m & PRESENT;
    off_sel = off_rail_m & PRESENT;
    on_ok   = (&(~on_gpi_m | gpi)) & (&(~on_sel | pg_ext));
    off_ok  = (&(~off_gpi_m | ~gpi)) & (&(~off_sel | ~pg_ext));
    gpi_rise = |(on_gpi_m & gpi & ~gpi_q);
  end
endmodule

// File: rtl/seq_fault_fanout.sv
module seq_fault_fanout #(
  parameter int NUM_RAILS = 4
) (
  input  logic [NUM_RAILS-1:0]           rail_fault,
  input  logic [NUM_RAILS*NUM_RAILS-1:0] slave_flat,
  output logic [NUM_RAILS-1:0]           fault_hit
);
  // fault_hit[j]: rail j's own fault, or a fault on any master i that names j
  always_comb begin
    for (int j = 0; j < NUM_RAILS; j++) begin
      fault_hit[j] = rail_fault[j];
      for (int i = 0; i < NUM_RAILS; i++) begin
        fault_hit[j] = fault_hit[j] | (rail_fault[i] & slave_flat[i*NUM_RAILS + j]);
      end
    end
  end
endmodule

// File: rtl/seq_rail_fsm.sv
module seq_rail_fsm
  import seq_pkg::*;
#(
  parameter int NUM_RAILS = 4,
  parameter int MASK_W    = 16,
  parameter int NUM_GPI   = 8,
  parameter int DLY_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_ms,
  input  logic                 wr_en,
  input  logic [NUM_GPI-1:0]   wr_on_gpi,
  input  logic [NUM_GPI-1:0]   wr_off_gpi,
  input  logic [MASK_W-1:0]    wr_on_rail,
  input  logic [MASK_W-1:0]    wr_off_rail,
  input  logic [NUM_RAILS-1:0] wr_slave,
  input  logic [DLY_W-1:0]     wr_ton,
  input  logic [DLY_W-1:0]     wr_toff,
  input  logic                 wr_pol,
  input  logic                 cmd_on,
  input  logic                 imm_off,
  input  logic                 fault_hit,
  input  logic                 on_ok,
  input  logic                 off_ok,
  input  logic                 gpi_rise,
  output logic [NUM_GPI-1:0]   on_gpi_m,
  output logic [NUM_GPI-1:0]   off_gpi_m,
  output logic [MASK_W-1:0]    on_rail_m,
  output logic [MASK_W-1:0]    off_rail_m,
  output logic [NUM_RAILS-1:0] slave_m,
  output logic                 rail_on,
  output logic                 en_pin
);
  rail_st_e         st;
  logic [DLY_W-1:0] cnt;
  logic [DLY_W-1:0] ton_r;
  logic [DLY_W-1:0] toff_r;
  logic             pol_r;
  logic             cmd_q;
  logic             rearm;

  assign rearm = (cmd_on & ~cmd_q) | gpi_rise;

  // configuration store
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_gpi_m   <= '0;
      off_gpi_m  <= '0;
      on_rail_m  <= '0;
      off_rail_m <= '0;
      slave_m    <= '0;
      ton_r      <= '0;
      toff_r     <= '0;
      pol_r      <= 1'b0;
    end else if (wr_en) begin
      on_gpi_m   <= wr_on_gpi;
      off_gpi_m  <= wr_off_gpi;
      on_rail_m  <= wr_on_rail;
      off_rail_m <= wr_off_rail;
      slave_m    <= wr_slave;
      ton_r      <= wr_ton;
      toff_r     <= wr_toff;
      pol_r      <= wr_pol;
    end
  end

  // rail state machine: fault first, then configuration write, then normal flow
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_OFF;
      cnt   <= '0;
      cmd_q <= 1'b0;
    end else begin
      cmd_q <= cmd_on;
      if (fault_hit) begin
        st <= ST_FAULT;
      end else if (wr_en) begin
        st <= (st == ST_FAULT) ? ST_FAULT : ST_OFF;
      end else begin
        unique case (st)
          ST_OFF: begin
            if (!imm_off && cmd_on && on_ok) begin
              if (ton_r == '0) st <= ST_ON;
              else begin
                st  <= ST_ON_DLY;
                cnt <= ton_r;
              end
            end
          end
          ST_ON_DLY: begin
            if (imm_off || !cmd_on) st <= ST_OFF;
            else if (tick_ms) begin
              if (cnt <= DLY_W'(1)) st <= ST_ON;
              cnt <= cnt - DLY_W'(1);
            end
          end
          ST_ON: begin
            if (imm_off) st <= ST_OFF;
            else if (!cmd_on && off_ok) begin
              if (toff_r == '0) st <= ST_OFF;
              else begin
                st  <= ST_OFF_DLY;
                cnt <= toff_r;
              end
            end
          end
          ST_OFF_DLY: begin
            if (imm_off) st <= ST_OFF;
            else if (cmd_on) st <= ST_ON;
            else if (tick_ms) begin
              if (cnt <= DLY_W'(1)) st <= ST_OFF;
              cnt <= cnt - DLY_W'(1);
            end
          end
          ST_FAULT: begin
            if (rearm) st <= ST_OFF;
          end
          default: st <= ST_OFF;
        endcase
      end
    end
  end

  assign rail_on = (st == ST_ON) || (st == ST_OFF_DLY);
  assign en_pin  = rail_on ^ pol_r;

  // R2: a rail only becomes on while its command is asserted
  assert_turn_on_needs_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_on) |-> $past(cmd_on));

  // R4: falling dependencies never switch an on rail off
  assert_on_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_on && cmd_on && !imm_off && !fault_hit && !wr_en) |=> rail_on);

  // R3: without a tick the turn-on delay cannot finish
  assert_delay_waits_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ON_DLY && !tick_ms && cmd_on && !imm_off && !fault_hit && !wr_en)
      |=> (st == ST_ON_DLY));

  // R6: immediate off acts on the next edge
  assert_imm_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    imm_off |=> !rail_on);

  // R7: a fault reaching this rail latches it in the fault state
  assert_fault_latches_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_hit |=> (st == ST_FAULT));

  // R8: no exit from the fault state without a rearm edge
  assert_fault_needs_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FAULT && !rearm) |=> (st == ST_FAULT));

  // R9: a configuration write releases the enable
  assert_cfg_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !rail_on);
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer #(
  parameter int NUM_RAILS = 4,
  parameter int MASK_W    = 16,
  parameter int NUM_GPI   = 8,
  parameter int DLY_W     = 8,
  localparam int SEL_W    = $clog2(MASK_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_ms,
  input  logic [NUM_GPI-1:0]   gpi,
  input  logic [NUM_RAILS-1:0] rail_pg,
  input  logic [NUM_RAILS-1:0] cmd_on,
  input  logic [NUM_RAILS-1:0] imm_off,
  input  logic [NUM_RAILS-1:0] rail_fault,
  input  logic                 cfg_we,
  input  logic [SEL_W-1:0]     cfg_sel,
  input  logic [NUM_GPI-1:0]   cfg_on_gpi,
  input  logic [NUM_GPI-1:0]   cfg_off_gpi,
  input  logic [MASK_W-1:0]    cfg_on_rail,
  input  logic [MASK_W-1:0]    cfg_off_rail,
  input  logic [NUM_RAILS-1:0] cfg_slave,
  input  logic [DLY_W-1:0]     cfg_ton,
  input  logic [DLY_W-1:0]     cfg_toff,
  input  logic                 cfg_pol,
  output logic [NUM_RAILS-1:0] en_pin
);
  logic [NUM_GPI-1:0]             gpi_q;
  logic [NUM_RAILS-1:0]           fault_hit;
  logic [NUM_RAILS*NUM_RAILS-1:0] slave_flat;
  logic [NUM_RAILS-1:0]           rail_on;

  always_ff @(posedge clk) begin
    if (!rst_n) gpi_q <= '0;
    else        gpi_q <= gpi;
  end

  seq_fault_fanout #(.NUM_RAILS(NUM_RAILS)) u_fanout (
    .rail_fault (rail_fault),
    .slave_flat (slave_flat),
    .fault_hit  (fault_hit)
  );

  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
    logic [NUM_GPI-1:0] on_gpi_m, off_gpi_m;
    logic [MASK_W-1:0]  on_rail_m, off_rail_m;
    logic               on_ok, off_ok, gpi_rise, wr_en;

    assign wr_en = cfg_we && (cfg_sel == SEL_W'(r));

    seq_dep_eval #(
      .NUM_RAILS(NUM_RAILS), .MASK_W(MASK_W), .NUM_GPI(NUM_GPI)
    ) u_dep (
      .gpi        (gpi),
      .gpi_q      (gpi_q),
      .rail_pg    (rail_pg),
      .on_gpi_m   (on_gpi_m),
      .off_gpi_m  (off_gpi_m),
      .on_rail_m  (on_rail_m),
      .off_rail_m (off_rail_m),
      .on_ok      (on_ok),
      .off_ok     (off_ok),
      .gpi_rise   (gpi_rise)
    );

    seq_rail_fsm #(
      .NUM_RAILS(NUM_RAILS), .MASK_W(MASK_W), .NUM_GPI(NUM_GPI), .DLY_W(DLY_W)
    ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_ms     (tick_ms),
      .wr_en       (wr_en),
      .wr_on_gpi   (cfg_on_gpi),
      .wr_off_gpi  (cfg_off_gpi),
      .wr_on_rail  (cfg_on_rail),
      .wr_off_rail (cfg_off_rail),
      .wr_slave    (cfg_slave),
      .wr_ton      (cfg_ton),
      .wr_toff     (cfg_toff),
      .wr_pol      (cfg_pol),
      .cmd_on      (cmd_on[r]),
      .imm_off     (imm_off[r]),
      .fault_hit   (fault_hit[r]),
      .on_ok       (on_ok),
      .off_ok      (off_ok),
      .gpi_rise    (gpi_rise),
      .on_gpi_m    (on_gpi_m),
      .off_gpi_m   (off_gpi_m),
      .on_rail_m   (on_rail_m),
      .off_rail_m  (off_rail_m),
      .slave_m     (slave_flat[r*NUM_RAILS +: NUM_RAILS]),
      .rail_on     (rail_on[r]),
      .en_pin      (en_pin[r])
    );
  end

  // R1: a rail becoming on must have had its own fault clear on that edge
  assert_no_on_under_fault_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_on[0]) |-> !$past(fault_hit[0]));
endmodule

// File: tb/rail_sequencer_test.sv
`timescale 1ns/1ps
module rail_sequencer_test;
  localparam int N = 4;
  localparam int G = 8;
  localparam int M = 16;
  localparam int D = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b0;
  logic [G-1:0] gpi = '0;
  logic [N-1:0] rail_pg = '0, cmd_on = '0, imm_off = '0, rail_fault = '0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_sel = '0;
  logic [G-1:0] cfg_on_gpi = '0, cfg_off_gpi = '0;
  logic [M-1:0] cfg_on_rail = '0, cfg_off_rail = '0;
  logic [N-1:0] cfg_slave = '0;
  logic [D-1:0] cfg_ton = '0, cfg_toff = '0;
  logic cfg_pol = 1'b0;
  logic [N-1:0] en_pin;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rail_sequencer #(.NUM_RAILS(N), .MASK_W(M), .NUM_GPI(G), .DLY_W(D)) uut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .gpi(gpi), .rail_pg(rail_pg),
    .cmd_on(cmd_on), .imm_off(imm_off), .rail_fault(rail_fault),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_on_gpi(cfg_on_gpi),
    .cfg_off_gpi(cfg_off_gpi), .cfg_on_rail(cfg_on_rail),
    .cfg_off_rail(cfg_off_rail), .cfg_slave(cfg_slave), .cfg_ton(cfg_ton),
    .cfg_toff(cfg_toff), .cfg_pol(cfg_pol), .en_pin(en_pin)
  );

  typedef struct packed {
    logic [3:0] cmd;
    logic [3:0] imm;
    logic [3:0] flt;
    logic [7:0] gp;
    logic [3:0] pg;
    logic [3:0] en;
    logic [7:0] req;
  } vec_t;

  // rail0: on needs gpi0, rail1 pg and absent rail10; off waits rail2 pg low; slave rail3
  localparam vec_t VEC [21] = '{
    '{4'b0000, 4'b0000, 4'b0000, 8'h00, 4'b0000, 4'b0000, 8'd1},  // idle
    '{4'b0001, 4'b0000, 4'b0000, 8'h00, 4'b0000, 4'b0000, 8'd1},  // R1 no deps
    '{4'b0001, 4'b0000, 4'b0000, 8'h01, 4'b0000, 4'b0000, 8'd1},  // R1 rail1 pg missing
    '{4'b0001, 4'b0000, 4'b0000, 8'h01, 4'b0010, 4'b0001, 8'd11}, // R11 bit10 ignored
    '{4'b0001, 4'b0000, 4'b0000, 8'h00, 4'b0000, 4'b0001, 8'd4},  // R4 deps fall
    '{4'b0000, 4'b0000, 4'b0000, 8'h00, 4'b0100, 4'b0001, 8'd5},  // R5 rail2 still good
    '{4'b0000, 4'b0000, 4'b0000, 8'h00, 4'b0000, 4'b0000, 8'd5},  // R5 off deps met
    '{4'b0000, 4'b0000, 4'b0000, 8'h01, 4'b0010, 4'b0000, 8'd2},  // R2 deps first
    '{4'b0001, 4'b0000, 4'b0000, 8'h01, 4'b0010, 4'b0001, 8'd2},  // R2 cmd last
    '{4'b1001, 4'b0000, 4'b0000, 8'h01, 4'b0010, 4'b1001, 8'd3},  // R3 zero delay
    '{4'b1001, 4'b0000, 4'b0001, 8'h01, 4'b0010, 4'b0000, 8'd7},  // R7 master+slave
    '{4'b1001, 4'b0000, 4'b0000, 8'h01, 4'b0010, 4'b0000, 8'd8},  // R8 no toggle
    '{4'b0000, 4'b0000, 4'b0000, 8'h01, 4'b0010, 4'b0000, 8'd8},  // R8 low
    '{4'b1001, 4'b0000, 4'b0000, 8'h01, 4'b0010, 4'b0000, 8'd8},  // R8 rise rearms
    '{4'b1001, 4'b0000, 4'b0000, 8'h01, 4'b0010, 4'b1001, 8'd8},  // R8 restart
    '{4'b1001, 4'b0001, 4'b0000, 8'h01, 4'b0110, 4'b1000, 8'd6},  // R6 imm off
    '{4'b1001, 4'b0000, 4'b0000, 8'h01, 4'b0110, 4'b1001, 8'd6},  // R6 back on
    '{4'b1001, 4'b0000, 4'b0001, 8'h01, 4'b0110, 4'b0000, 8'd7},  // R7 again
    '{4'b1001, 4'b0000, 4'b0000, 8'h00, 4'b0110, 4'b0000, 8'd8},  // R8 gpi low
    '{4'b1001, 4'b0000, 4'b0000, 8'h01, 4'b0110, 4'b0000, 8'd8},  // R8 gpi rise
    '{4'b1001, 4'b0000, 4'b0000, 8'h01, 4'b0110, 4'b0001, 8'd8}   // R8 slave still off
  };

  task automatic check(input logic [N-1:0] act, input logic [N-1:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s en_pin actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic write_cfg(input int sel, input logic [G-1:0] ong, input logic [M-1:0] onr,
                           input logic [M-1:0] offr, input logic [N-1:0] slv,
                           input logic [D-1:0] ton, input logic [D-1:0] toff, input logic pol);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 4'(sel); cfg_on_gpi = ong; cfg_off_gpi = '0;
    cfg_on_rail = onr; cfg_off_rail = offr; cfg_slave = slv;
    cfg_ton = ton; cfg_toff = toff; cfg_pol = pol;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic tick_pulse();
    @(negedge clk); tick_ms = 1'b1;
    @(negedge clk); tick_ms = 1'b0;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(en_pin, 4'b0000, "R12 reset");

    write_cfg(0, 8'h01, 16'h0402, 16'h0004, 4'b1000, 8'd0, 8'd0, 1'b0);

    for (int k = 0; k < 21; k++) begin
      @(negedge clk);
      cmd_on = VEC[k].cmd; imm_off = VEC[k].imm; rail_fault = VEC[k].flt;
      gpi = VEC[k].gp; rail_pg = VEC[k].pg;
      @(negedge clk);
      check(en_pin, VEC[k].en, $sformatf("R%0d vector %0d", VEC[k].req, k));
    end

    // clear everything; rail3 still latched needs its command toggled
    @(negedge clk);
    cmd_on = '0; gpi = '0; rail_pg = '0; imm_off = '0; rail_fault = '0;
    repeat (2) @(negedge clk);
    check(en_pin, 4'b0000, "R8 all off");

    // R10 polarity on rail2
    write_cfg(2, 8'h00, 16'h0000, 16'h0000, 4'b0000, 8'd0, 8'd0, 1'b1);
    check(en_pin, 4'b0100, "R10 inverted idle");
    cmd_on[2] = 1'b1;
    @(negedge clk);
    check(en_pin, 4'b0000, "R10 inverted on");
    cmd_on[2] = 1'b0;
    @(negedge clk);

    // R9 write releases then re-enables
    cmd_on[1] = 1'b1;
    @(negedge clk);
    check(en_pin, 4'b0110, "R9 rail1 on");
    write_cfg(1, 8'h00, 16'h0000, 16'h0000, 4'b0000, 8'd0, 8'd0, 1'b0);
    check(en_pin, 4'b0100, "R9 released");
    @(negedge clk);
    check(en_pin, 4'b0110, "R9 re-enabled");

    // R9 write to an absent rail changes nothing
    write_cfg(9, 8'hFF, 16'hFFFF, 16'hFFFF, 4'b1111, 8'd5, 8'd5, 1'b1);
    check(en_pin, 4'b0110, "R9 absent index ignored");

    // R3 turn-on delay of 3 ticks
    write_cfg(1, 8'h00, 16'h0000, 16'h0000, 4'b0000, 8'd3, 8'd2, 1'b0);
    check(en_pin, 4'b0100, "R3 released by write");
    repeat (3) @(negedge clk);
    check(en_pin, 4'b0100, "R3 waits without tick");
    tick_pulse();
    tick_pulse();
    check(en_pin, 4'b0100, "R3 after two ticks");
    tick_pulse();
    check(en_pin, 4'b0110, "R3 after third tick");

    // R5 turn-off delay of 2 ticks
    cmd_on[1] = 1'b0;
    repeat (2) @(negedge clk);
    check(en_pin, 4'b0110, "R5 off delay running");
    tick_pulse();
    check(en_pin, 4'b0110, "R5 after one tick");
    tick_pulse();
    check(en_pin, 4'b0100, "R5 after second tick");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule